// File: doc/BRIEF.md
# Segment Interrupt Pending Controller

This block keeps one interrupt-pending flag per memory segment and folds them into a single interrupt request. Each segment carries two control bits that are supplied from outside:
- an interrupt bit, which makes an access to the segment raise its pending flag;
- an enable bit, whose clearing wipes the flag and keeps it at zero.

Software can also set or clear any pending flag directly through a write port.

A global interrupt-enable register gates the request. On a read strobe, a pointer register is loaded with the lowest-numbered segment whose flag is set. When no flag is set, the pointer instead carries a no-valid marker. An 8-bit vector register is returned on the low data byte during an interrupt acknowledge cycle. The acknowledge is held until the data strobes go away.

All inputs are plain strobes sampled on the rising clock edge. The block never stalls, so none of its interfaces has back-pressure: every access, write, read or acknowledge request offered in a cycle is taken in that cycle. Every output comes from a register or from a function of registers only. Up to 32 segments are supported, and the pointer index field is 5 bits wide.

Top module: `seg_irq_ctrl`

## Requirements
- R1: An access strobe to segment i, with segment i's interrupt bit and enable bit both at 1, sets pending flag i at the next clock edge.
- R2: An access strobe to a segment whose interrupt bit is 0 leaves every pending flag unchanged.
- R3: A pending write to segment i loads the written value (1 sets, 0 clears) into flag i. If a write and an access to the same segment fall in one cycle, the write wins.
- R4: While a segment's enable bit is 0, its pending flag is cleared at every clock edge and cannot be set by access or write.
- R5: The local-pending output is 1 exactly when at least one pending flag is 1.
- R6: The interrupt request is 1 exactly when local-pending is 1 and the global enable register (written through its own write strobe) is 1.
- R7: A pointer read strobe loads the pointer register from the flags as they stand in that cycle, putting the lowest set segment number in bits 4..0. Without a read strobe the pointer holds its value.
- R8: Pointer bit 7 is 1 when no flag was set at the read, and bits 6 and 5 are always 0. In the no-valid case the pointer value is 0x80.
- R9: The vector register is 8 bits, loads on its write strobe, is visible on its own output, and resets to 0x0F.
- R10: When the interrupt request, the acknowledge request and at least one data strobe are 1 in a cycle, the acknowledge output rises at the next edge with the vector on the data byte. It stays high while any data strobe stays 1 and drops at the edge after both strobes are 0. The data byte is 0 while no acknowledge is given.
- R11: Reset clears all pending flags and the global enable, drops the acknowledge, sets the pointer to 0x80 and the vector to 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Segment access strobe |
| acc_idx | input | IDX_W | Index of the accessed segment |
| seg_int_en | input | NSEG | Per-segment interrupt-on-access bits |
| seg_en | input | NSEG | Per-segment enable bits |
| pend_wr | input | 1 | Pending flag write strobe |
| pend_wr_idx | input | IDX_W | Segment addressed by the pending write |
| pend_wr_val | input | 1 | Value written to the pending flag |
| gie_wr | input | 1 | Global enable write strobe |
| gie_wr_val | input | 1 | Global enable write value |
| vec_wr | input | 1 | Vector register write strobe |
| vec_wr_data | input | 8 | Vector register write value |
| ptr_rd | input | 1 | Pointer read strobe |
| ack_req | input | 1 | Interrupt acknowledge request |
| ds | input | 2 | Data strobes (upper, lower) |
| pend_q | output | NSEG | Current pending flags |
| loc_pend | output | 1 | OR of all pending flags |
| irq | output | 1 | Interrupt request |
| ptr_q | output | 8 | Interrupt pointer register |
| vec_q | output | 8 | Vector register value |
| ack_o | output | 1 | Acknowledge output |
| ack_data | output | 8 | Low data byte during acknowledge |

## Verification
The bench builds the block with its default of 32 segments. With that value, indices 0 and 31 reach both ends of the 5-bit pointer field, and the lowest-index priority is exercised across the full flag vector. A behavioural model is compared with every output on every cycle. Directed sequences and a long random phase together cover:
- writes and accesses to the same segment in one cycle;
- enable bits dropping while a flag is set;
- pointer reads with no flag set;
- acknowledge requests made while the global enable is off.

// File: rtl/seg_irq_pkg.sv
package seg_irq_pkg;

  localparam int PTR_W     = 8;
  localparam int PTR_IDX_W = 5;

  typedef struct packed {
    logic                 none;
    logic [1:0]           rsvd;
    logic [PTR_IDX_W-1:0] idx;
  } irq_ptr_t;

  localparam irq_ptr_t PTR_EMPTY = '{none: 1'b1, rsvd: 2'b00, idx: '0};

  function automatic irq_ptr_t make_ptr(input logic found, input logic [PTR_IDX_W-1:0] idx);
    irq_ptr_t p;
    p.none = ~found;
    p.rsvd = 2'b00;
    p.idx  = found ? idx : '0;
    return p;
  endfunction

endpackage

// File: rtl/seg_pend_bank.sv
module seg_pend_bank #(
  parameter int NSEG  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [NSEG-1:0]  seg_int_en,
  input  logic [NSEG-1:0]  seg_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  output logic [NSEG-1:0]  pend
);

  for (genvar g = 0; g < NSEG; g++) begin : g_flag
    logic hit_acc;
    logic hit_wr;

    assign hit_acc = acc_valid && (acc_idx == IDX_W'(g)) && seg_int_en[g];
    assign hit_wr  = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
      end else if (!seg_en[g]) begin
        pend[g] <= 1'b0;
      end else if (hit_wr) begin
        pend[g] <= wr_val;
      end else if (hit_acc) begin
        pend[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_prio_enc.sv
module seg_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/seg_ack_unit.sv
module seg_ack_unit #(
  parameter int         VEC_W   = 8,
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wr_data,
  input  logic             irq,
  input  logic             ack_req,
  input  logic [1:0]       ds,
  output logic [VEC_W-1:0] vec_q,
  output logic             ack_q,
  output logic [VEC_W-1:0] data_out
);

  logic any_ds;
  logic start;

  assign any_ds = |ds;
  assign start  = irq && ack_req && any_ds;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= VEC_W'(VEC_RST);
    end else if (vec_wr) begin
      vec_q <= vec_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else if (ack_q) begin
      ack_q <= any_ds;
    end else begin
      ack_q <= start;
    end
  end

  assign data_out = ack_q ? vec_q : '0;

endmodule

// File: rtl/seg_irq_ctrl.sv
module seg_irq_ctrl
  import seg_irq_pkg::*;
#(
  parameter int NSEG  = 32,
  parameter int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [NSEG-1:0]  seg_int_en,
  input  logic [NSEG-1:0]  seg_en,
  input  logic             pend_wr,
  input  logic [IDX_W-1:0] pend_wr_idx,
  input  logic             pend_wr_val,
  input  logic             gie_wr,
  input  logic             gie_wr_val,
  input  logic             vec_wr,
  input  logic [7:0]       vec_wr_data,
  input  logic             ptr_rd,
  input  logic             ack_req,
  input  logic [1:0]       ds,
  output logic [NSEG-1:0]  pend_q,
  output logic             loc_pend,
  output logic             irq,
  output logic [7:0]       ptr_q,
  output logic [7:0]       vec_q,
  output logic             ack_o,
  output logic [7:0]       ack_data
);

  localparam int ENC_W = PTR_IDX_W;

  logic             gie_q;
  logic             enc_found;
  logic [ENC_W-1:0] enc_idx;
  irq_ptr_t         ptr_r;

  seg_pend_bank #(.NSEG(NSEG), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_idx    (acc_idx),
    .seg_int_en (seg_int_en),
    .seg_en     (seg_en),
    .wr_en      (pend_wr),
    .wr_idx     (pend_wr_idx),
    .wr_val     (pend_wr_val),
    .pend       (pend_q)
  );

  seg_prio_enc #(.N(NSEG), .IDX_W(ENC_W)) u_enc (
    .req   (pend_q),
    .found (enc_found),
    .idx   (enc_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_wr) begin
      gie_q <= gie_wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_r <= PTR_EMPTY;
    end else if (ptr_rd) begin
      ptr_r <= make_ptr(enc_found, enc_idx);
    end
  end

  assign loc_pend = |pend_q;
  assign irq      = loc_pend && gie_q;
  assign ptr_q    = ptr_r;

  seg_ack_unit #(.VEC_W(8), .VEC_RST(8'h0F)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_wr      (vec_wr),
    .vec_wr_data (vec_wr_data),
    .irq         (irq),
    .ack_req     (ack_req),
    .ds          (ds),
    .vec_q       (vec_q),
    .ack_q       (ack_o),
    .data_out    (ack_data)
  );

endmodule

// File: rtl/seg_irq_ctrl_chk.sv
module seg_irq_ctrl_chk #(
  parameter int NSEG  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [IDX_W-1:0] acc_idx,
  input logic [NSEG-1:0]  seg_int_en,
  input logic [NSEG-1:0]  seg_en,
  input logic             pend_wr,
  input logic [IDX_W-1:0] pend_wr_idx,
  input logic             ptr_rd,
  input logic [1:0]       ds,
  input logic [NSEG-1:0]  pend_q,
  input logic             loc_pend,
  input logic             irq,
  input logic [7:0]       ptr_q,
  input logic             ack_o,
  input logic [7:0]       ack_data
);

  // R1
  a_r1_access_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && seg_int_en[acc_idx] && seg_en[acc_idx] &&
     !(pend_wr && pend_wr_idx == acc_idx)) |=> pend_q[$past(acc_idx)]);

  // R4
  a_r4_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(seg_en)) == '0));

  // R6
  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q != '0));

  // R8
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[6:5] == 2'b00);

  // R8
  a_r8_none_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd |=> (ptr_q[7] == ($past(pend_q) == '0)));

  // R7
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_rd |=> $stable(ptr_q));

  // R10
  a_r10_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && ds != 2'b00) |=> ack_o);

  // R10
  a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ds == 2'b00) |=> !ack_o);

  // R10
  a_r10_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> (ack_data == 8'h00));

endmodule

bind seg_irq_ctrl seg_irq_ctrl_chk #(.NSEG(NSEG), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_idx     (acc_idx),
  .seg_int_en  (seg_int_en),
  .seg_en      (seg_en),
  .pend_wr     (pend_wr),
  .pend_wr_idx (pend_wr_idx),
  .ptr_rd      (ptr_rd),
  .ds          (ds),
  .pend_q      (pend_q),
  .loc_pend    (loc_pend),
  .irq         (irq),
  .ptr_q       (ptr_q),
  .ack_o       (ack_o),
  .ack_data    (ack_data)
);

// File: tb/seg_irq_ctrl_bench.sv
`timescale 1ns/1ps
module seg_irq_ctrl_bench;

  localparam int NSEG  = 32;
  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic [IDX_W-1:0] acc_idx = '0;
  logic [NSEG-1:0]  seg_int_en = '0;
  logic [NSEG-1:0]  seg_en = '0;
  logic             pend_wr = 1'b0;
  logic [IDX_W-1:0] pend_wr_idx = '0;
  logic             pend_wr_val = 1'b0;
  logic             gie_wr = 1'b0;
  logic             gie_wr_val = 1'b0;
  logic             vec_wr = 1'b0;
  logic [7:0]       vec_wr_data = '0;
  logic             ptr_rd = 1'b0;
  logic             ack_req = 1'b0;
  logic [1:0]       ds = '0;
  logic [NSEG-1:0]  pend_q;
  logic             loc_pend, irq, ack_o;
  logic [7:0]       ptr_q, vec_q, ack_data;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  seg_irq_ctrl #(.NSEG(NSEG), .IDX_W(IDX_W)) u_seg_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .seg_int_en(seg_int_en), .seg_en(seg_en), .pend_wr(pend_wr),
    .pend_wr_idx(pend_wr_idx), .pend_wr_val(pend_wr_val), .gie_wr(gie_wr),
    .gie_wr_val(gie_wr_val), .vec_wr(vec_wr), .vec_wr_data(vec_wr_data),
    .ptr_rd(ptr_rd), .ack_req(ack_req), .ds(ds), .pend_q(pend_q),
    .loc_pend(loc_pend), .irq(irq), .ptr_q(ptr_q), .vec_q(vec_q),
    .ack_o(ack_o), .ack_data(ack_data)
  );

  // behavioural reference model
  logic [NSEG-1:0] m_pend, m_old;
  logic            m_gie, m_ack, m_irq_old;
  logic [7:0]      m_ptr, m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_gie = 1'b0; m_ack = 1'b0; m_ptr = 8'h80; m_vec = 8'h0F;
    end else begin
      m_old     = m_pend;
      m_irq_old = (m_old != 0) && m_gie;
      if (ptr_rd) begin
        m_ptr = 8'h80;
        for (int i = NSEG - 1; i >= 0; i--) if (m_old[i]) m_ptr = 8'(i);
      end
      if (m_ack) m_ack = (ds != 2'b00);
      else       m_ack = m_irq_old && ack_req && (ds != 2'b00);
      for (int i = 0; i < NSEG; i++) begin
        if (!seg_en[i])                                m_pend[i] = 1'b0;
        else if (pend_wr && int'(pend_wr_idx) == i)    m_pend[i] = pend_wr_val;
        else if (acc_valid && int'(acc_idx) == i && seg_int_en[i]) m_pend[i] = 1'b1;
      end
      if (gie_wr) m_gie = gie_wr_val;
      if (vec_wr) m_vec = vec_wr_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R3 R4 pending flags", pend_q, m_pend);
    chk("R5 local pending", 32'(loc_pend), 32'(m_pend != 0));
    chk("R6 interrupt request", 32'(irq), 32'((m_pend != 0) && m_gie));
    chk("R7 R8 pointer", 32'(ptr_q), 32'(m_ptr));
    chk("R9 vector", 32'(vec_q), 32'(m_vec));
    chk("R10 acknowledge", 32'(ack_o), 32'(m_ack));
    chk("R10 data byte", 32'(ack_data), 32'(m_ack ? m_vec : 8'h00));
  endtask

  task automatic clear_strobes();
    acc_valid = 0; pend_wr = 0; gie_wr = 0; vec_wr = 0; ptr_rd = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare_all();
    clear_strobes();
  endtask

  initial begin
    #(1500000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pending after reset", pend_q, 0);
    chk("R11 irq after reset", 32'(irq), 0);
    chk("R11 ack after reset", 32'(ack_o), 0);
    chk("R8 R11 pointer reset 0x80", 32'(ptr_q), 32'h80);
    chk("R9 R11 vector reset 0x0F", 32'(vec_q), 32'h0F);

    seg_en = '1;
    seg_int_en = (32'd1 << 5) | (32'd1 << 20) | 32'd1;
    gie_wr = 1; gie_wr_val = 1;
    step();
    acc_valid = 1; acc_idx = 5'd3;
    step();
    chk("R2 access with interrupt bit clear", pend_q, 0);
    acc_valid = 1; acc_idx = 5'd20;
    step();
    chk("R1 access sets flag 20", pend_q, 32'd1 << 20);
    acc_valid = 1; acc_idx = 5'd5;
    step();
    chk("R5 local pending set", 32'(loc_pend), 1);
    chk("R6 irq with enable", 32'(irq), 1);
    ptr_rd = 1;
    step();
    chk("R7 pointer lowest is 5", 32'(ptr_q), 32'h05);

    pend_wr = 1; pend_wr_idx = 5'd5; pend_wr_val = 0;
    step();
    ptr_rd = 1;
    step();
    chk("R3 R7 pointer after clear is 20", 32'(ptr_q), 32'h14);

    pend_wr = 1; pend_wr_idx = 5'd31; pend_wr_val = 1;
    step();
    pend_wr = 1; pend_wr_idx = 5'd20; pend_wr_val = 0;
    step();
    ptr_rd = 1;
    step();
    chk("R3 R7 pointer index 31", 32'(ptr_q), 32'h1F);

    seg_en[31] = 1'b0;
    step();
    chk("R4 disabled segment cleared", pend_q, 0);
    pend_wr = 1; pend_wr_idx = 5'd31; pend_wr_val = 1;
    step();
    chk("R4 write to disabled segment ignored", pend_q, 0);
    ptr_rd = 1;
    step();
    chk("R8 no-valid pointer", 32'(ptr_q), 32'h80);
    seg_en = '1;

    acc_valid = 1; acc_idx = 5'd0; pend_wr = 1; pend_wr_idx = 5'd0; pend_wr_val = 0;
    step();
    chk("R3 write wins over access", pend_q, 0);

    vec_wr = 1; vec_wr_data = 8'hA5;
    step();
    chk("R9 vector written", 32'(vec_q), 32'hA5);

    pend_wr = 1; pend_wr_idx = 5'd0; pend_wr_val = 1;
    step();
    ptr_rd = 1;
    step();
    chk("R7 pointer index 0", 32'(ptr_q), 32'h00);
    ack_req = 1; ds = 2'b01;
    step();
    chk("R10 ack given", 32'(ack_o), 1);
    chk("R10 vector on data byte", 32'(ack_data), 32'hA5);
    ack_req = 0; ds = 2'b10;
    step();
    step();
    chk("R10 ack held while strobe", 32'(ack_o), 1);
    ds = 2'b00;
    step();
    chk("R10 ack dropped", 32'(ack_o), 0);
    chk("R10 data idle", 32'(ack_data), 0);

    gie_wr = 1; gie_wr_val = 0;
    step();
    chk("R6 irq off with enable clear", 32'(irq), 0);
    chk("R5 local pending still set", 32'(loc_pend), 1);
    ack_req = 1; ds = 2'b11;
    step();
    chk("R10 no ack without request", 32'(ack_o), 0);
    ack_req = 0; ds = 2'b00;
    step();

    for (int n = 0; n < 4000; n++) begin
      acc_valid   = ($urandom % 3) == 0;
      acc_idx     = IDX_W'($urandom);
      if (($urandom % 8) == 0) seg_int_en = $urandom;
      if (($urandom % 16) == 0) seg_en = $urandom | $urandom | $urandom;
      pend_wr     = ($urandom % 5) == 0;
      pend_wr_idx = IDX_W'($urandom);
      pend_wr_val = 1'($urandom);
      gie_wr      = ($urandom % 10) == 0;
      gie_wr_val  = ($urandom % 4) != 0;
      vec_wr      = ($urandom % 20) == 0;
      vec_wr_data = 8'($urandom);
      ptr_rd      = ($urandom % 3) == 0;
      ack_req     = ($urandom % 4) == 0;
      ds          = 2'($urandom);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule